// File: doc/BRIEF.md
# Parallel ADC Conversion Controller

This block sits on the host side of a parallel-output successive-approximation converter. It drives the converter's chip-select, convert-start, read-strobe and shutdown lines and watches its active-low busy flag. Each result is captured into a holding register and offered to the rest of the chip through a valid/ready handshake. While `run` is high, conversions repeat back to back, no faster than a minimum start-to-start period.

Three interface styles are selectable through `cfg_mode`:

- **Free-running (0):** chip-select and read stay low, and the word is taken when busy rises.
- **Bus-shared (1):** the bus is only read with a separate read pulse after busy has risen.
- **Combined (2):** one strobe drives convert-start and read together, so each read returns the word from the conversion before.

Power-down is sequenced on request. Chip-select is set to the requested depth before shutdown is pulled low: low selects nap and high selects sleep. When shutdown is released, the controller waits a depth-specific wake time before the next start. All timing is given in controller clock cycles through parameters. Busy is resynchronised through a flop chain, and a missing busy edge is reported as a timeout.

Top module: `adc_conv_ctrl`

## Requirements
- R1: A convert-start falling edge is only produced while `adc_cs_n` is 0 and `adc_shdn_n` is 1.
- R2: No new convert-start falling edge is produced while the converter's busy line is low, including after a timeout with busy still held low.
- R3: Every convert-start low pulse lasts exactly `STROBE_CYC` cycles.
- R4: Two consecutive convert-start falling edges are at least `PERIOD_CYC` cycles apart.
- R5: With `cfg_mode`=0, `adc_rd_n` is 0 during the start pulse, and the delivered word is the one the converter finished most recently.
- R6: With `cfg_mode`=1, `adc_rd_n` is 1 during the start pulse. It goes low only after busy has risen and stays low for exactly `RD_CYC` cycles. The word is sampled during that pulse.
- R7: With `cfg_mode`=2, `adc_rd_n` equals `adc_convst_n`, and the delivered word is the one present when the strobe began, which is the previous conversion's result.
- R8: While `adc_shdn_n` is 0, `adc_cs_n` is stable. It is 0 for a nap request (`pd_deep`=0) and 1 for a sleep request (`pd_deep`=1), and it is already set one cycle before shutdown falls.
- R9: After `adc_shdn_n` rises, the next start edge comes no sooner than `NAP_WAKE_CYC` cycles (nap) or `SLEEP_WAKE_CYC` cycles (sleep).
- R10: If busy has not risen within 2×`TCONV_MAX_CYC` cycles after the start pulse ends, `timeout_err` pulses for one cycle exactly `STROBE_CYC`+2×`TCONV_MAX_CYC` cycles after the start edge.
- R11: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and `res_data` hold. An accepted word clears `res_valid`.
- R12: A new word that arrives while the old one is unaccepted replaces it and sets `res_overrun`. `res_overrun` clears when a word is accepted.
- R13: During reset, `adc_cs_n`=0, `adc_convst_n`=1, `adc_rd_n`=1, `adc_shdn_n`=1, and `res_valid`, `res_overrun` and `timeout_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Interface style: 0 free-running, 1 bus-shared, 2 combined (3 acts as 1) |
| run | input | 1 | Keep converting while high |
| pd_req | input | 1 | Request power-down while high |
| pd_deep | input | 1 | Depth of the requested power-down: 0 nap, 1 sleep |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_convst_n | output | 1 | Converter start line; a falling edge starts a conversion |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_shdn_n | output | 1 | Converter shutdown, active low |
| adc_busy_n | input | 1 | Converter busy flag, low while converting (asynchronous) |
| adc_data | input | DATA_W | Converter parallel data bus |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | DATA_W | Result word |
| res_overrun | output | 1 | An unaccepted word was overwritten |
| timeout_err | output | 1 | One-cycle pulse on a missing busy edge |

## Verification
The bench models a converter whose bus reads zero unless selected and read, so a controller that samples too early, or without a read pulse, delivers zero instead of the converted word. In combined mode the bench expects the word that was present at the strobe. A controller that waited for busy would return the fresh word and be caught. A busy line held low past the timeout checks both the exact timeout cycle and that no restart occurs while busy is still low. Overrun, nap and sleep wake-up, and random mixes of mode and conversion length check the handshake hold, the depth encoding on chip-select and the start-to-start spacing.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_BUS  = 2'd1,
        MODE_COMB = 2'd2
    } ifmode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STROBE,
        S_CONV,
        S_READ,
        S_PD_SETUP,
        S_PD_HOLD,
        S_WAKE
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic convst_n;
        logic rd_n;
        logic shdn_n;
    } adc_pins_t;

    function automatic ifmode_e decode_mode(input logic [1:0] m);
        case (m)
            2'd0:    return MODE_FREE;
            2'd2:    return MODE_COMB;
            default: return MODE_BUS;
        endcase
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_n_async,
    output logic busy_n_s,
    output logic busy_rise
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              level_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= busy_n_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], busy_n_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= chain[TOP];
    end

    assign busy_n_s  = chain[TOP];
    assign busy_rise = chain[TOP] & ~level_q;

endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              valid,
    input  logic              ready,
    output logic [DATA_W-1:0] data,
    output logic              overrun
);
    logic taken;
    assign taken = valid & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            data    <= '0;
            overrun <= 1'b0;
        end else if (push) begin
            data  <= push_data;
            valid <= 1'b1;
            if (valid && !ready) overrun <= 1'b1;
            else if (taken)      overrun <= 1'b0;
        end else if (taken) begin
            valid   <= 1'b0;
            overrun <= 1'b0;
        end
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !push) |=> (valid && $stable(data)));

    p_overrun_r12: assert property (@(posedge clk) disable iff (rst)
        (push && valid && !ready) |=> overrun);

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_ctrl_pkg::*;
#(
    parameter int STROBE_CYC     = 4,
    parameter int RD_CYC         = 4,
    parameter int PERIOD_CYC     = 160,
    parameter int TCONV_MAX_CYC  = 130,
    parameter int NAP_WAKE_CYC   = 40,
    parameter int SLEEP_WAKE_CYC = 2000000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [1:0] cfg_mode,
    input  logic      run,
    input  logic      pd_req,
    input  logic      pd_deep,
    input  logic      busy_n_s,
    input  logic      busy_rise,
    output adc_pins_t pins,
    output logic      push,
    output logic      timeout_o
);
    localparam int TIMEOUT_CYC = 2 * TCONV_MAX_CYC;
    localparam int CNT_MAX     = max2(max2(max2(STROBE_CYC, RD_CYC), TIMEOUT_CYC),
                                      max2(NAP_WAKE_CYC, SLEEP_WAKE_CYC));
    localparam int CNT_W       = $clog2(CNT_MAX + 1);
    localparam int PER_W       = $clog2(PERIOD_CYC + 1);
    localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST  = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] NAP_LAST = CNT_W'(NAP_WAKE_CYC - 1);
    localparam logic [CNT_W-1:0] SLP_LAST = CNT_W'(SLEEP_WAKE_CYC - 1);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(PERIOD_CYC - 1);

    seq_state_e       state;
    ifmode_e          mode_q;
    logic             deep_q;
    logic [CNT_W-1:0] cnt;
    logic [PER_W-1:0] per_cnt;
    logic             per_ok;
    logic [CNT_W-1:0] wake_last;

    assign per_ok    = (per_cnt == PER_LAST);
    assign wake_last = deep_q ? SLP_LAST : NAP_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            mode_q    <= MODE_BUS;
            deep_q    <= 1'b0;
            cnt       <= '0;
            per_cnt   <= PER_LAST;
            timeout_o <= 1'b0;
        end else begin
            timeout_o <= 1'b0;
            if (!per_ok) per_cnt <= per_cnt + 1'b1;
            case (state)
                S_IDLE: begin
                    cnt    <= '0;
                    mode_q <= decode_mode(cfg_mode);
                    if (pd_req) begin
                        deep_q <= pd_deep;
                        state  <= S_PD_SETUP;
                    end else if (run && per_ok && busy_n_s) begin
                        per_cnt <= '0;
                        state   <= S_STROBE;
                    end
                end
                S_STROBE: begin
                    if (cnt == STB_LAST) begin
                        cnt   <= '0;
                        state <= S_CONV;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_CONV: begin
                    if (busy_rise) begin
                        cnt   <= '0;
                        state <= (mode_q == MODE_BUS) ? S_READ : S_IDLE;
                    end else if (cnt == TO_LAST) begin
                        timeout_o <= 1'b1;
                        state     <= S_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_READ: begin
                    if (cnt == RD_LAST) state <= S_IDLE;
                    else                cnt   <= cnt + 1'b1;
                end
                S_PD_SETUP: state <= S_PD_HOLD;
                S_PD_HOLD: begin
                    cnt <= '0;
                    if (!pd_req) state <= S_WAKE;
                end
                S_WAKE: begin
                    if (cnt == wake_last) state <= S_IDLE;
                    else                  cnt   <= cnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    logic in_pd;
    assign in_pd = (state == S_PD_SETUP) || (state == S_PD_HOLD) || (state == S_WAKE);

    always_comb begin
        pins.cs_n     = in_pd ? deep_q : 1'b0;
        pins.shdn_n   = (state != S_PD_HOLD);
        pins.convst_n = (state != S_STROBE);
        if (in_pd) begin
            pins.rd_n = 1'b1;
        end else begin
            case (mode_q)
                MODE_FREE: pins.rd_n = 1'b0;
                MODE_COMB: pins.rd_n = (state != S_STROBE);
                default:   pins.rd_n = (state != S_READ);
            endcase
        end
    end

    always_comb begin
        push = 1'b0;
        if (state == S_STROBE && mode_q == MODE_COMB && cnt == STB_LAST) push = 1'b1;
        if (state == S_CONV && busy_rise && mode_q == MODE_FREE)          push = 1'b1;
        if (state == S_READ && cnt == RD_LAST)                            push = 1'b1;
    end

    // Checker state, kept apart from the control path
    localparam int GAP_W = $clog2(PERIOD_CYC + 2);
    logic             cv_q;
    logic             fall_now;
    logic             conv_open;
    logic             seen_fall;
    logic [15:0]      low_cnt;
    logic [GAP_W-1:0] gap_cnt;

    assign fall_now = cv_q & ~pins.convst_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cv_q      <= 1'b1;
            conv_open <= 1'b0;
            seen_fall <= 1'b0;
            low_cnt   <= '0;
            gap_cnt   <= '0;
        end else begin
            cv_q <= pins.convst_n;
            if (fall_now)                    conv_open <= 1'b1;
            else if (busy_rise || timeout_o) conv_open <= 1'b0;
            if (fall_now) seen_fall <= 1'b1;
            low_cnt <= pins.convst_n ? 16'd0 : low_cnt + 16'd1;
            if (fall_now)                             gap_cnt <= GAP_W'(1);
            else if (gap_cnt != GAP_W'(PERIOD_CYC))   gap_cnt <= gap_cnt + 1'b1;
        end
    end

    p_start_cond_r1: assert property (@(posedge clk) disable iff (rst)
        fall_now |-> (!pins.cs_n && pins.shdn_n));

    p_no_restart_r2: assert property (@(posedge clk) disable iff (rst)
        fall_now |-> !conv_open);

    p_strobe_len_r3: assert property (@(posedge clk) disable iff (rst)
        (!cv_q && pins.convst_n) |-> (low_cnt == 16'(STROBE_CYC)));

    p_period_r4: assert property (@(posedge clk) disable iff (rst)
        (fall_now && seen_fall) |-> (gap_cnt >= GAP_W'(PERIOD_CYC)));

    p_pd_cs_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !pins.shdn_n |-> $stable(pins.cs_n));

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int SYNC_STAGES    = 2,
    parameter int STROBE_CYC     = 4,
    parameter int RD_CYC         = 4,
    parameter int PERIOD_CYC     = 160,
    parameter int TCONV_MAX_CYC  = 130,
    parameter int NAP_WAKE_CYC   = 40,
    parameter int SLEEP_WAKE_CYC = 2000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic              run,
    input  logic              pd_req,
    input  logic              pd_deep,
    output logic              adc_cs_n,
    output logic              adc_convst_n,
    output logic              adc_rd_n,
    output logic              adc_shdn_n,
    input  logic              adc_busy_n,
    input  logic [DATA_W-1:0] adc_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              res_overrun,
    output logic              timeout_err
);
    logic      busy_n_s;
    logic      busy_rise;
    logic      push;
    adc_pins_t pins;

    adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .busy_n_async (adc_busy_n),
        .busy_n_s     (busy_n_s),
        .busy_rise    (busy_rise)
    );

    adc_seq #(
        .STROBE_CYC     (STROBE_CYC),
        .RD_CYC         (RD_CYC),
        .PERIOD_CYC     (PERIOD_CYC),
        .TCONV_MAX_CYC  (TCONV_MAX_CYC),
        .NAP_WAKE_CYC   (NAP_WAKE_CYC),
        .SLEEP_WAKE_CYC (SLEEP_WAKE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cfg_mode  (cfg_mode),
        .run       (run),
        .pd_req    (pd_req),
        .pd_deep   (pd_deep),
        .busy_n_s  (busy_n_s),
        .busy_rise (busy_rise),
        .pins      (pins),
        .push      (push),
        .timeout_o (timeout_err)
    );

    adc_result_buf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (adc_data),
        .valid     (res_valid),
        .ready     (res_ready),
        .data      (res_data),
        .overrun   (res_overrun)
    );

    assign adc_cs_n     = pins.cs_n;
    assign adc_convst_n = pins.convst_n;
    assign adc_rd_n     = pins.rd_n;
    assign adc_shdn_n   = pins.shdn_n;

    p_reset_state_r13: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !res_overrun && !timeout_err));

endmodule

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;
    localparam int DW   = 12;
    localparam int STB  = 4;
    localparam int RDC  = 3;
    localparam int PER  = 40;
    localparam int TCM  = 20;
    localparam int NAPW = 10;
    localparam int SLPW = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = 2'd0;
    logic          run = 1'b0, pd_req = 1'b0, pd_deep = 1'b0, res_ready = 1'b1;
    logic          cs_n, convst_n, rd_n, shdn_n, res_valid, res_overrun, timeout_err;
    logic          adc_busy_n;
    logic [DW-1:0] adc_data, res_data;

    adc_conv_ctrl #(
        .DATA_W(DW), .SYNC_STAGES(2), .STROBE_CYC(STB), .RD_CYC(RDC),
        .PERIOD_CYC(PER), .TCONV_MAX_CYC(TCM), .NAP_WAKE_CYC(NAPW), .SLEEP_WAKE_CYC(SLPW)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .run(run), .pd_req(pd_req),
        .pd_deep(pd_deep), .adc_cs_n(cs_n), .adc_convst_n(convst_n), .adc_rd_n(rd_n),
        .adc_shdn_n(shdn_n), .adc_busy_n(adc_busy_n), .adc_data(adc_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_overrun(res_overrun), .timeout_err(timeout_err)
    );

    always #2.5 clk = ~clk;

    // Converter model
    logic          busy_pin = 1'b1;
    logic          cv_prev = 1'b1;
    logic [DW-1:0] dout = '0, at_start = '0;
    int            mcnt = 0, conv_len = 10, nstarts = 0;
    bit            stuck = 1'b0;

    assign adc_busy_n = busy_pin;
    assign adc_data   = (!cs_n && !rd_n) ? dout : '0;

    always @(posedge clk) begin
        cv_prev <= convst_n;
        if (rst) begin
            busy_pin <= 1'b1;
            mcnt     <= 0;
        end else if (cv_prev && !convst_n && !cs_n && shdn_n && busy_pin) begin
            busy_pin <= 1'b0;
            mcnt     <= conv_len;
            at_start <= dout;
            nstarts  <= nstarts + 1;
        end else if (!busy_pin) begin
            if (mcnt > 1) mcnt <= mcnt - 1;
            else if (!stuck) begin
                busy_pin <= 1'b1;
                dout     <= DW'($urandom);
            end
        end
    end

    // Checking
    int n_checks = 0, n_fails = 0, n_results = 0, n_timeouts = 0;
    int cyc = 0, gap = 0, lowlen = 0, rdlen = 0, last_fall = 0, wake_mark = 0;
    bit have_fall = 0, wake_pend = 0, wake_deep = 0, chk_mode = 0, done = 0;
    logic cv_q = 1'b1, rd_q = 1'b1, shdn_q = 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] exp_word(input logic [1:0] m);
        return (m == 2'd2) ? at_start : dout;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        return (m == 2'd0) ? "R5" : (m == 2'd2) ? "R7" : "R6";
    endfunction

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (cv_q && !convst_n) begin
                chk(!cs_n && shdn_n, "R1", {cs_n, shdn_n}, 1);
                chk(busy_pin === 1'b1, "R2", busy_pin, 1);
                if (have_fall) chk(gap >= PER, "R4", gap, PER);
                if (wake_pend) begin
                    chk(cyc - wake_mark >= (wake_deep ? SLPW : NAPW), "R9",
                        cyc - wake_mark, wake_deep ? SLPW : NAPW);
                    wake_pend = 0;
                end
                have_fall = 1; gap = 0; last_fall = cyc;
            end
            if (!cv_q && convst_n) chk(lowlen == STB, "R3", lowlen, STB);
            lowlen = convst_n ? 0 : lowlen + 1;
            gap++;
            if (chk_mode) begin
                case (cfg_mode)
                    2'd0: if (!convst_n) chk(rd_n == 1'b0, "R5", rd_n, 0);
                    2'd2: chk(rd_n == convst_n, "R7", rd_n, convst_n);
                    default: begin
                        if (!convst_n) chk(rd_n == 1'b1, "R6", rd_n, 1);
                        if (rd_q && !rd_n) chk(busy_pin == 1'b1, "R6", busy_pin, 1);
                        if (!rd_q && rd_n) chk(rdlen == RDC, "R6", rdlen, RDC);
                    end
                endcase
            end
            rdlen = rd_n ? 0 : rdlen + 1;
            if (!shdn_q && shdn_n) begin
                wake_mark = cyc; wake_pend = 1; wake_deep = pd_deep;
            end
            if (res_valid && res_ready) begin
                chk(res_data == exp_word(cfg_mode), mode_tag(cfg_mode),
                    int'(res_data), int'(exp_word(cfg_mode)));
                n_results++;
            end
            if (timeout_err) begin
                chk(cyc - last_fall == STB + 2 * TCM, "R10", cyc - last_fall, STB + 2 * TCM);
                n_timeouts++;
            end
            cv_q = convst_n; rd_q = rd_n; shdn_q = shdn_n;
        end
        if (cyc > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        step(1); run = 1'b0;
        step(60);
    endtask

    task automatic run_mode(input logic [1:0] m, input int n);
        int base;
        go_idle();
        cfg_mode = m; chk_mode = 0;
        step(3); chk_mode = 1;
        base = n_results;
        run = 1'b1;
        while (n_results < base + n) @(negedge clk);
        go_idle();
    endtask

    initial begin
        int ns;
        int base;
        logic [DW-1:0] d0;
        void'($urandom(32'd1851));
        step(3);
        @(negedge clk);
        chk(cs_n == 0 && convst_n == 1 && rd_n == 1 && shdn_n == 1, "R13",
            {cs_n, convst_n, rd_n, shdn_n}, 4'b0111);
        chk(!res_valid && !res_overrun && !timeout_err, "R13",
            {res_valid, res_overrun, timeout_err}, 0);
        step(1); rst = 1'b0;

        // Directed: each interface style
        conv_len = 12; run_mode(2'd0, 4);
        conv_len = 18; run_mode(2'd1, 4);
        conv_len = 7;  run_mode(2'd2, 4);

        // Missing busy edge: timeout, then no restart while busy held low
        cfg_mode = 2'd0; stuck = 1'b1; conv_len = 10;
        step(1); run = 1'b1;
        while (n_timeouts < 1) @(negedge clk);
        ns = nstarts;
        step(60);
        chk(nstarts == ns, "R2", nstarts, ns);
        chk(n_timeouts == 1, "R10", n_timeouts, 1);
        stuck = 1'b0;
        base = n_results;
        while (n_results < base + 2) @(negedge clk);
        go_idle();

        // Overrun: consumer stalls across two results
        res_ready = 1'b0;
        base = nstarts;
        run = 1'b1;
        while (!res_valid) @(negedge clk);
        d0 = res_data;
        while (nstarts < base + 2) @(negedge clk);
        step(1); run = 1'b0;
        @(negedge clk);
        chk(res_valid && res_data == d0, "R11", int'(res_data), int'(d0));
        step(60);
        @(negedge clk);
        chk(res_valid == 1'b1, "R11", res_valid, 1);
        chk(res_overrun == 1'b1, "R12", res_overrun, 1);
        chk(res_data == dout, "R12", int'(res_data), int'(dout));
        step(1); res_ready = 1'b1;
        step(2);
        @(negedge clk);
        chk(!res_valid && !res_overrun, "R12", {res_valid, res_overrun}, 0);

        // Nap then sleep
        for (int k = 0; k < 2; k++) begin
            go_idle();
            pd_deep = (k == 1); pd_req = 1'b1; run = 1'b1;
            step(10);
            @(negedge clk);
            chk(shdn_n == 1'b0, "R8", shdn_n, 0);
            chk(cs_n == pd_deep, "R8", cs_n, pd_deep);
            step(1); pd_req = 1'b0;
            base = n_results;
            while (n_results < base + 2) @(negedge clk);
        end
        go_idle();

        // Random mixes of style and conversion length
        for (int i = 0; i < 12; i++) begin
            conv_len = $urandom_range(TCM, 6);
            run_mode(2'($urandom_range(2, 0)), $urandom_range(3, 1));
        end
        chk(!res_overrun, "R12", res_overrun, 0);
        finish_run();
    end
endmodule